// File: doc/BRIEF.md
# Sample-Period Timer with Phase Nudge

This block divides a master clock into sampling periods. A down-counter is loaded with the programmed period length. Each time the counter reloads, the block emits a one-clock period strobe, which marks one conversion. Period and step values presented at the inputs are taken only when the counter reloads. A change made in the middle of a period therefore never disturbs the count in progress.

Phase is adjusted with two request inputs, advance and retard. Requests seen during a period are collected. At the next reload the period that then starts is shortened (advance) or lengthened (retard) by the step value, counted in master-clock cycles. After that one adjusted period the nominal length resumes. A steady drift therefore needs a request in every period. For example, a period of 1298 cycles of a 10.386 MHz clock is about 125 µs, and a step of 10 moves the strobe by about 963 ns per request. The adjusting output is high for the whole of an adjusted period.

Top module: `sample_period_timer`

## Requirements
- R1: With no request, consecutive strobes are exactly max(period_i, 2) clocks apart. strobe_o is high for one clock each time.
- R2: An advance request makes the next period max(P - S, 2) clocks long. P is the clamped period and S is step_i.
- R3: A retard request makes the next period P + S clocks long.
- R4: Only the one period that follows the request is adjusted. The period after it returns to P unless a new request is made.
- R5: Any number of same-direction requests within one period give a single adjustment of S.
- R6: If both advance and retard are seen within the same period, the next period has the nominal length and adjusting_o stays low.
- R7: period_i and step_i are sampled only on the clock edge where the counter reloads. A change during a period leaves that period's length unchanged.
- R8: A shortened period is never less than 2 clocks, even when S is greater than or equal to P - 2.
- R9: adjusting_o rises together with the strobe that starts an adjusted period. It stays constant until the next strobe and is low for nominal periods.
- R10: While rst_n is low, strobe_o and adjusting_o are 0. The first strobe comes on the first clock edge after rst_n goes high, and that period uses period_i sampled on that edge.
- R11: A request sampled on the same edge that raises the strobe counts toward the period that this strobe starts. A request sampled one edge later counts toward the period after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Nominal period length in clocks (values below 2 act as 2) |
| step_i | input | STEP_W | Phase step in clocks |
| adv_req_i | input | 1 | Advance request: shortens one period |
| ret_req_i | input | 1 | Retard request: lengthens one period |
| strobe_o | output | 1 | One-clock pulse at each counter reload |
| adjusting_o | output | 1 | High during a period whose length was adjusted |

## Verification
The strobe and adjusting_o change on the reload edge, one register after the count reaches zero. The monitor samples both on the falling edge after that reload edge. A request held during edge e changes the length measured between the strobe that follows e and the strobe after it. The scoreboard therefore pushes each period's expected length during the period before it and pops it when that period's closing strobe is seen. The request timings next to a reload (the last cycle of a period and the first cycle of the next) are driven at exact falling-edge offsets, so that the edge each one is sampled on is known.

// File: rtl/spt_pkg.sv
package spt_pkg;

    // Shortest period the counter may run, in clocks
    localparam int unsigned SPT_MIN_LEN = 2;

    typedef enum logic [1:0] {
        ADJ_NONE     = 2'd0,
        ADJ_SHORTEN  = 2'd1,
        ADJ_LENGTHEN = 2'd2
    } adj_dir_e;

endpackage

// File: rtl/spt_req_capture.sv
module spt_req_capture
    import spt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv_i,
    input  logic     ret_i,
    input  logic     close_i,
    output adj_dir_e dir_o
);

    typedef struct packed {
        logic adv;
        logic ret;
    } req_t;

    req_t req_d, req_q;
    logic adv_now, ret_now;

    always_comb begin
        adv_now = req_q.adv | adv_i;
        ret_now = req_q.ret | ret_i;
        if (adv_now && !ret_now)
            dir_o = ADJ_SHORTEN;
        else if (ret_now && !adv_now)
            dir_o = ADJ_LENGTHEN;
        else
            dir_o = ADJ_NONE;
        // Collected requests are consumed at the reload
        req_d = close_i ? '0 : '{adv: adv_now, ret: ret_now};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

endmodule

// File: rtl/spt_len_calc.sv
module spt_len_calc
    import spt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STEP_W = 8,
    parameter int LEN_W  = CNT_W + 1
) (
    input  logic [CNT_W-1:0]  period_i,
    input  logic [STEP_W-1:0] step_i,
    input  adj_dir_e          dir_i,
    output logic [LEN_W-1:0]  len_o
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(SPT_MIN_LEN);

    logic [LEN_W-1:0] base, step_x;

    always_comb begin
        base   = (LEN_W'(period_i) < MIN_L) ? MIN_L : LEN_W'(period_i);
        step_x = LEN_W'(step_i);
        unique case (dir_i)
            ADJ_SHORTEN:  len_o = (base >= step_x + MIN_L) ? base - step_x : MIN_L;
            ADJ_LENGTHEN: len_o = base + step_x;
            default:      len_o = base;
        endcase
    end

endmodule

// File: rtl/sample_period_timer.sv
module sample_period_timer
    import spt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              adv_req_i,
    input  logic              ret_req_i,
    output logic              strobe_o,
    output logic              adjusting_o
);

    localparam int LEN_W = CNT_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             strobe;
        logic             adjusting;
    } state_t;

    state_t           state_d, state_q;
    logic             close;
    adj_dir_e         dir;
    logic [LEN_W-1:0] next_len;

    assign close = (state_q.cnt == '0);

    spt_req_capture u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv_req_i),
        .ret_i   (ret_req_i),
        .close_i (close),
        .dir_o   (dir)
    );

    spt_len_calc #(
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W),
        .LEN_W  (LEN_W)
    ) u_len (
        .period_i (period_i),
        .step_i   (step_i),
        .dir_i    (dir),
        .len_o    (next_len)
    );

    always_comb begin
        state_d        = state_q;
        state_d.strobe = close;
        if (close) begin
            state_d.cnt       = next_len - LEN_W'(1);
            state_d.adjusting = (dir != ADJ_NONE);
        end else begin
            state_d.cnt = state_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign strobe_o    = state_q.strobe;
    assign adjusting_o = state_q.adjusting;

endmodule

module sample_period_timer_chk #(
    parameter int LEN_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_o,
    input logic             adjusting_o,
    input logic [LEN_W-1:0] cnt_i
);

    // R1
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R1
    strobe_at_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(cnt_i == '0));

    // R8
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |=> (cnt_i != '0));

    // R7
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |=> (cnt_i == $past(cnt_i) - 1'b1));

    // R9
    adj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> $stable(adjusting_o));

endmodule

bind sample_period_timer sample_period_timer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_o    (strobe_o),
    .adjusting_o (adjusting_o),
    .cnt_i       (state_q.cnt)
);

// File: tb/tb_sample_period_timer.sv
module tb_sample_period_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int STEP_W = 8;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [CNT_W-1:0]  period_i = 0;
    logic [STEP_W-1:0] step_i = 0;
    logic              adv_req_i = 0;
    logic              ret_req_i = 0;
    logic              strobe_o, adjusting_o;

    int total = 0;
    int bad = 0;
    int cur_len;

    int    q_len[$];
    bit    q_adj[$];
    string q_tag[$];

    sample_period_timer #(.CNT_W(CNT_W), .STEP_W(STEP_W)) dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .step_i(step_i),
        .adv_req_i(adv_req_i), .ret_req_i(ret_req_i),
        .strobe_o(strobe_o), .adjusting_o(adjusting_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int p, input int s, input bit a, input bit r);
        int base;
        base = (p < 2) ? 2 : p;
        if (a && !r) return (base >= s + 2) ? base - s : 2;
        if (r && !a) return base + s;
        return base;
    endfunction

    // Driver: runs one period, pushes expectation for the following one
    task automatic run_period(input int aoff, input int alen, input int roff,
                              input int rlen, input int np, input int ns,
                              input string tag);
        bit a_any, r_any;
        int nxt;
        do @(negedge clk); while (!strobe_o);
        a_any = (alen > 0);
        r_any = (rlen > 0);
        nxt = exp_len(np, ns, a_any, r_any);
        q_len.push_back(nxt);
        q_adj.push_back(a_any ^ r_any);
        q_tag.push_back(tag);
        for (int j = 0; j < cur_len; j++) begin
            if (j > 0) @(negedge clk);
            if (j == 0) begin
                period_i = CNT_W'(np);
                step_i   = STEP_W'(ns);
            end
            adv_req_i = a_any && (j >= aoff) && (j < aoff + alen);
            ret_req_i = r_any && (j >= roff) && (j < roff + rlen);
        end
        cur_len = nxt;
    endtask

    // Monitor: measures each period and compares with the scoreboard
    initial begin
        int  cnt;
        bit  started;
        bit  adj_rec;
        bit  adj_moved;
        string tg;
        int  el;
        bit  ea;
        started = 0;
        cnt = 0;
        adj_rec = 0;
        adj_moved = 0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (strobe_o) begin
                if (started) begin
                    if (q_len.size() == 0) begin
                        check(0, "scoreboard-empty", cnt + 1, 0);
                    end else begin
                        el = q_len.pop_front();
                        ea = q_adj.pop_front();
                        tg = q_tag.pop_front();
                        check(cnt + 1 == el, {tg, " period length"}, cnt + 1, el);
                        check(adj_rec == ea && !adj_moved, {tg, " R9 adjusting"},
                              int'(adj_rec), int'(ea));
                    end
                end
                started = 1;
                cnt = 0;
                adj_rec = adjusting_o;
                adj_moved = 0;
            end else begin
                cnt++;
                if (adjusting_o != adj_rec) adj_moved = 1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        period_i = 20;
        step_i   = 3;
        cur_len  = 20;
        q_len.push_back(20);
        q_adj.push_back(0);
        q_tag.push_back("R10");
        repeat (3) @(negedge clk);
        // R10: outputs idle while reset is held
        check(strobe_o == 0, "R10 strobe in reset", int'(strobe_o), 0);
        check(adjusting_o == 0, "R10 adjusting in reset", int'(adjusting_o), 0);
        rst_n = 1;
        @(posedge clk);
        #1;
        check(strobe_o == 1, "R10 first strobe", int'(strobe_o), 1);

        run_period(0, 0, 0, 0, 20, 3, "R1");
        run_period(5, 1, 0, 0, 20, 3, "R2");
        run_period(0, 0, 0, 0, 20, 3, "R4");
        run_period(0, 0, 2, 1, 20, 3, "R3");
        run_period(0, 0, 0, 0, 20, 3, "R4");
        run_period(3, 6, 0, 0, 20, 3, "R5");
        run_period(4, 1, 4, 1, 20, 3, "R6");
        run_period(19, 1, 0, 0, 20, 3, "R11 last cycle");
        run_period(0, 1, 0, 0, 20, 3, "R11 first cycle");
        run_period(0, 0, 0, 0, 30, 5, "R7");
        run_period(6, 1, 0, 0, 30, 5, "R7 new step");
        run_period(1, 1, 0, 0, 30, 28, "R8");
        run_period(0, 1, 0, 0, 3, 10, "R8 small period");
        run_period(0, 0, 0, 0, 0, 1, "R1 zero period");
        run_period(0, 0, 0, 0, 1298, 10, "R1 long");
        run_period(100, 1, 0, 0, 1298, 10, "R2 long");
        run_period(0, 0, 500, 1, 1298, 10, "R3 long");
        run_period(0, 0, 0, 0, 1298, 10, "R4 long");
        @(negedge clk);
        adv_req_i = 0;
        ret_req_i = 0;
        wait (q_len.size() == 0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule